// File: doc/BRIEF.md
# Impedance Calibration Sweep Sequencer

This block drives the impedance-calibration hardware of a memory PHY and finds a 5-bit strength code for three legs: the pull-up drive, the pull-down drive and the pull-down termination. It works on one leg at a time. For each leg it loads a reference-voltage select code and sets the pull-up and pull-down enables. It then steps the drive code upward from zero. After each step it waits a settle interval and reads a comparator bit. The first code that meets the leg's pass condition becomes that leg's result. The pull-up termination leg is not swept, and its result is reported as zero.

A run begins with a start pulse while the sequencer is idle. The termination on/off selector is captured at that point and picks the reference table used for the whole run. The impedance circuit and reference enables come on first. After one settle interval the calibration enable rises. When the run ends, the calibration enable and the leg enables return to the values they held before the run, and a one-cycle done pulse marks that the results are valid. The comparator arrives from the analog domain, so it passes through a two-flop synchroniser before it is used.

Top module: `imp_cal_seq`

## Requirements
- R1: Legs run in the fixed order pull-up drive, pull-down drive, pull-down termination. At the end of a run the pull-up termination result reads 0.
- R2: On entry to each leg, vref_sel is loaded from a table indexed by the selector captured at start. With the selector low the codes are pull-up drive 0x37, pull-down drive 0x33 and pull-down termination 0x37. With it high they are 0x3A, 0x33 and 0x3A.
- R3: The enables per leg are: pull-up drive en_pu=1, en_pd=0; pull-down drive en_pu=0, en_pd=0; pull-down termination en_pu=0, en_pd=1. The two enables are never high together.
- R4: Each leg sweeps its code upward from 0 in steps of 1. After every code change the sequencer waits SETTLE_CYC cycles before it samples the comparator.
- R5: The pull-up drive leg passes when the comparator reads 1. The two pull-down legs pass when it reads 0. The first passing code is stored as the leg's result, with its fail flag at 0.
- R6: If no code from 0 to 31 passes, the leg's result is 31 and its fail flag is 1.
- R7: pu_code is swept from 0 during the pull-up drive leg. During both pull-down legs it holds the pull-up drive result. Both pull-down legs sweep pd_code.
- R8: After start, imp_en and vref_en go high in the next cycle. cal_en rises exactly SETTLE_CYC cycles after that.
- R9: At the end of a run, cal_en, en_pu and en_pd take back the values captured at start (all 0 from idle), and imp_en and vref_en drop to 0.
- R10: After reset, all four results read 0xFF and the fail flags read 0. Each start sets the results back to 0xFF and clears the fail flags.
- R11: done is high for exactly one cycle per run. A start seen while busy is ignored and does not restart or alter the run.
- R12: The comparator is sampled only through a two-flop synchroniser, so the value the sequencer uses lags cmp_in by two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| odt_on | input | 1 | Termination on/off selector, captured at start |
| cmp_in | input | 1 | Asynchronous comparator result |
| pu_code | output | 5 | Pull-up strength code |
| pd_code | output | 5 | Pull-down strength code |
| vref_sel | output | 6 | Reference-voltage select code |
| en_pu | output | 1 | Pull-up calibration enable |
| en_pd | output | 1 | Pull-down calibration enable |
| imp_en | output | 1 | Impedance circuit enable |
| vref_en | output | 1 | Reference enable |
| cal_en | output | 1 | Calibration enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| res_pu_drv | output | 8 | Pull-up drive result |
| res_pd_drv | output | 8 | Pull-down drive result |
| res_pu_term | output | 8 | Pull-up termination result (0 after a run) |
| res_pd_term | output | 8 | Pull-down termination result |
| fail_pu_drv | output | 1 | Pull-up drive sweep found no passing code |
| fail_pd_drv | output | 1 | Pull-down drive sweep found no passing code |
| fail_pd_term | output | 1 | Pull-down termination sweep found no passing code |

## Verification
The bench's comparator model passes a leg only when the enables, the reference code for the captured selector and the held pull-up code are all correct. A design that swaps the polarity, the table entries or the enable pattern therefore returns clamped results with fail flags set, and one that lets pu_code drift during the pull-down legs never passes them. Targets at code 0, at code 31 and beyond 31 show an off-by-one in the sweep bound or a missing clamp, because either gives a wrong result or a wrong fail flag. The bench also measures the power-up delay to cal_en to the exact cycle. It sends a second start with the other selector value in the middle of a run, and a design that restarts on it returns results computed with the wrong reference code.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
  typedef enum logic [1:0] {
    LEG_PU_DRV  = 2'd0,
    LEG_PD_DRV  = 2'd1,
    LEG_PD_TERM = 2'd2
  } leg_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_SETTLE,
    ST_SAMPLE,
    ST_FINISH
  } state_e;

  typedef struct packed {
    logic cal;
    logic pu;
    logic pd;
  } ctrl_t;
endpackage

// File: rtl/cmp_sync2.sv
module cmp_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || expired) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vref_table.sv
module vref_table
  import imp_cal_pkg::*;
#(
  parameter int          VREF_W      = 6,
  parameter logic [5:0]  OFF_PU_DRV  = 6'h37,
  parameter logic [5:0]  OFF_PD_DRV  = 6'h33,
  parameter logic [5:0]  OFF_PD_TERM = 6'h37,
  parameter logic [5:0]  ON_PU_DRV   = 6'h3A,
  parameter logic [5:0]  ON_PD_DRV   = 6'h33,
  parameter logic [5:0]  ON_PD_TERM  = 6'h3A
) (
  input  logic              odt,
  input  leg_e              leg,
  output logic [VREF_W-1:0] code
);
  always_comb begin
    unique case (leg)
      LEG_PU_DRV:  code = VREF_W'(odt ? ON_PU_DRV  : OFF_PU_DRV);
      LEG_PD_DRV:  code = VREF_W'(odt ? ON_PD_DRV  : OFF_PD_DRV);
      LEG_PD_TERM: code = VREF_W'(odt ? ON_PD_TERM : OFF_PD_TERM);
      default:     code = '0;
    endcase
  end
endmodule

// File: rtl/imp_cal_seq.sv
module imp_cal_seq
  import imp_cal_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int VREF_W     = 6,
  parameter int RES_W      = 8,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              odt_on,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code,
  output logic [VREF_W-1:0] vref_sel,
  output logic              en_pu,
  output logic              en_pd,
  output logic              imp_en,
  output logic              vref_en,
  output logic              cal_en,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  res_pu_drv,
  output logic [RES_W-1:0]  res_pd_drv,
  output logic [RES_W-1:0]  res_pu_term,
  output logic [RES_W-1:0]  res_pd_term,
  output logic              fail_pu_drv,
  output logic              fail_pd_drv,
  output logic              fail_pd_term
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [RES_W-1:0]  RES_INIT = '1;
  localparam int                PAD_W    = RES_W - CODE_W;

  state_e            st;
  leg_e              leg, leg_nxt;
  logic [CODE_W-1:0] code_q, pu_hold;
  logic              odt_q;
  ctrl_t             saved;
  logic              cmp_s, tmr_run, tmr_exp, pass, last_code;
  logic [VREF_W-1:0] vref_nxt;
  logic [RES_W-1:0]  code_res;

  cmp_sync2 u_sync (.clk(clk), .rst(rst), .d(cmp_in), .q(cmp_s));

  settle_timer #(.LIMIT(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(tmr_run), .expired(tmr_exp)
  );

  assign tmr_run = (st == ST_POWER) || (st == ST_SETTLE);
  assign leg_nxt = (st == ST_POWER) ? LEG_PU_DRV : leg_e'(leg + 2'd1);

  vref_table #(.VREF_W(VREF_W)) u_vref (.odt(odt_q), .leg(leg_nxt), .code(vref_nxt));

  assign pass      = (leg == LEG_PU_DRV) ? cmp_s : ~cmp_s;
  assign last_code = (code_q == CODE_MAX);
  assign code_res  = {{PAD_W{1'b0}}, code_q};
  assign pu_code   = (leg == LEG_PU_DRV) ? code_q : pu_hold;
  assign pd_code   = (leg == LEG_PU_DRV) ? '0 : code_q;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      leg          <= LEG_PU_DRV;
      code_q       <= '0;
      pu_hold      <= '0;
      odt_q        <= 1'b0;
      saved        <= '0;
      vref_sel     <= '0;
      en_pu        <= 1'b0;
      en_pd        <= 1'b0;
      imp_en       <= 1'b0;
      vref_en      <= 1'b0;
      cal_en       <= 1'b0;
      done         <= 1'b0;
      res_pu_drv   <= RES_INIT;
      res_pd_drv   <= RES_INIT;
      res_pu_term  <= RES_INIT;
      res_pd_term  <= RES_INIT;
      fail_pu_drv  <= 1'b0;
      fail_pd_drv  <= 1'b0;
      fail_pd_term <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st           <= ST_POWER;
          imp_en       <= 1'b1;
          vref_en      <= 1'b1;
          odt_q        <= odt_on;
          saved        <= '{cal: cal_en, pu: en_pu, pd: en_pd};
          leg          <= LEG_PU_DRV;
          code_q       <= '0;
          pu_hold      <= '0;
          res_pu_drv   <= RES_INIT;
          res_pd_drv   <= RES_INIT;
          res_pu_term  <= RES_INIT;
          res_pd_term  <= RES_INIT;
          fail_pu_drv  <= 1'b0;
          fail_pd_drv  <= 1'b0;
          fail_pd_term <= 1'b0;
        end
        ST_POWER: if (tmr_exp) begin
          cal_en   <= 1'b1;
          en_pu    <= 1'b1;
          en_pd    <= 1'b0;
          vref_sel <= vref_nxt;
          leg      <= LEG_PU_DRV;
          code_q   <= '0;
          st       <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp) st <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (pass || last_code) begin
            unique case (leg)
              LEG_PU_DRV: begin
                res_pu_drv  <= code_res;
                fail_pu_drv <= ~pass;
                pu_hold     <= code_q;
              end
              LEG_PD_DRV: begin
                res_pd_drv  <= code_res;
                fail_pd_drv <= ~pass;
              end
              default: begin
                res_pd_term  <= code_res;
                fail_pd_term <= ~pass;
              end
            endcase
            if (leg == LEG_PD_TERM) begin
              st <= ST_FINISH;
            end else begin
              leg      <= leg_nxt;
              code_q   <= '0;
              vref_sel <= vref_nxt;
              en_pu    <= 1'b0;
              en_pd    <= (leg_nxt == LEG_PD_TERM);
              st       <= ST_SETTLE;
            end
          end else begin
            code_q <= code_q + 1'b1;
            st     <= ST_SETTLE;
          end
        end
        ST_FINISH: begin
          done        <= 1'b1;
          cal_en      <= saved.cal;
          en_pu       <= saved.pu;
          en_pd       <= saved.pd;
          imp_en      <= 1'b0;
          vref_en     <= 1'b0;
          res_pu_term <= '0;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imp_cal_seq_chk.sv
module imp_cal_seq_chk #(
  parameter int CODE_W = 5,
  parameter int VREF_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cmp_in,
  input logic              cmp_s,
  input logic [CODE_W-1:0] pu_code,
  input logic [CODE_W-1:0] pd_code,
  input logic [VREF_W-1:0] vref_sel,
  input logic              en_pu,
  input logic              en_pd,
  input logic              imp_en,
  input logic              vref_en,
  input logic              cal_en,
  input logic              busy,
  input logic              done
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)             age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_cal_powered_r8: assert property (@(posedge clk) disable iff (rst)
    cal_en |-> (imp_en && vref_en));

  p_en_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    en_pu |-> !en_pd);

  p_pd_vref_r2: assert property (@(posedge clk) disable iff (rst)
    (cal_en && !en_pu && !en_pd) |-> (vref_sel == VREF_W'(6'h33)));

  p_end_restore_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cal_en && !en_pu && !en_pd && !imp_en && !vref_en));

  p_pu_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_en && !en_pu && $past(cal_en)) |-> $stable(pu_code));

  p_sweep_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cal_en && $past(cal_en) && !en_pu && $past(!en_pu) && (pd_code != $past(pd_code)))
      |-> ((pd_code == CODE_W'($past(pd_code) + 1'b1)) || (pd_code == '0)));

  p_sync_lag_r12: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (cmp_s == $past(cmp_in, 2)));
endmodule

bind imp_cal_seq imp_cal_seq_chk #(.CODE_W(CODE_W), .VREF_W(VREF_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in), .cmp_s(cmp_s),
  .pu_code(pu_code), .pd_code(pd_code), .vref_sel(vref_sel),
  .en_pu(en_pu), .en_pd(en_pd), .imp_en(imp_en), .vref_en(vref_en),
  .cal_en(cal_en), .busy(busy), .done(done)
);

// File: tb/imp_cal_seq_tb_top.sv
`timescale 1ns/1ps
module imp_cal_seq_tb_top;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic odt_on = 1'b0;
  logic cmp_in;
  logic [4:0] pu_code, pd_code;
  logic [5:0] vref_sel;
  logic en_pu, en_pd, imp_en, vref_en, cal_en, busy, done;
  logic [7:0] res_pu_drv, res_pd_drv, res_pu_term, res_pd_term;
  logic fail_pu_drv, fail_pd_drv, fail_pd_term;

  int checks = 0;
  int errors = 0;
  int tp = 0, tn = 0, tt = 0, exp_pu = 0;
  bit run_odt = 1'b0;

  always #5 clk = ~clk;

  imp_cal_seq #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .start(start), .odt_on(odt_on), .cmp_in(cmp_in),
    .pu_code(pu_code), .pd_code(pd_code), .vref_sel(vref_sel),
    .en_pu(en_pu), .en_pd(en_pd), .imp_en(imp_en), .vref_en(vref_en),
    .cal_en(cal_en), .busy(busy), .done(done),
    .res_pu_drv(res_pu_drv), .res_pd_drv(res_pd_drv),
    .res_pu_term(res_pu_term), .res_pd_term(res_pd_term),
    .fail_pu_drv(fail_pu_drv), .fail_pd_drv(fail_pd_drv), .fail_pd_term(fail_pd_term)
  );

  // Comparator and resistor network model: passes only with the right setup.
  always_comb begin
    logic [5:0] term_vref;
    term_vref = run_odt ? 6'h3A : 6'h37;
    cmp_in = 1'b0;
    if (en_pu && !en_pd)
      cmp_in = (vref_sel == term_vref) && (int'(pu_code) >= tp);
    else if (!en_pu && !en_pd)
      cmp_in = !((vref_sel == 6'h33) && (int'(pu_code) == exp_pu) && (int'(pd_code) >= tn));
    else if (!en_pu && en_pd)
      cmp_in = !((vref_sel == term_vref) && (int'(pu_code) == exp_pu) && (int'(pd_code) >= tt));
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int clampv(input int t);
    return (t > 31) ? 31 : t;
  endfunction

  task automatic kick(input bit odt, input int a, input int b, input int c);
    tp = a; tn = b; tt = c; run_odt = odt; exp_pu = clampv(a);
    @(negedge clk); odt_on = odt; start = 1'b1;
    @(negedge clk); start = 1'b0; odt_on = 1'b0;
  endtask

  task automatic finish_and_check(input string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " R11 done seen"}, int'(done), 1);
    chk({tag, " R5 R6 pull-up drive result"}, int'(res_pu_drv), clampv(tp));
    chk({tag, " R6 pull-up drive fail"}, int'(fail_pu_drv), int'(tp > 31));
    chk({tag, " R5 R7 pull-down drive result"}, int'(res_pd_drv), clampv(tn));
    chk({tag, " R6 pull-down drive fail"}, int'(fail_pd_drv), int'(tn > 31));
    chk({tag, " R1 R2 termination result"}, int'(res_pd_term), clampv(tt));
    chk({tag, " R6 termination fail"}, int'(fail_pd_term), int'(tt > 31));
    chk({tag, " R1 pull-up term zero"}, int'(res_pu_term), 0);
    chk({tag, " R9 restore"}, int'({cal_en, en_pu, en_pd, imp_en, vref_en}), 0);
    @(negedge clk);
    chk({tag, " R11 single pulse"}, int'(done), 0);
    chk({tag, " R11 idle"}, int'(busy), 0);
  endtask

  // {odt, pull-up target, pull-down target, termination target}; 32 = never passes
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'd5,  8'd9,  8'd12},
    {8'd1, 8'd0,  8'd0,  8'd0},
    {8'd0, 8'd31, 8'd31, 8'd31},
    {8'd1, 8'd32, 8'd7,  8'd3},
    {8'd0, 8'd17, 8'd32, 8'd32},
    {8'd1, 8'd3,  8'd32, 8'd0},
    {8'd0, 8'd32, 8'd32, 8'd32},
    {8'd1, 8'd12, 8'd20, 8'd31}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset result", int'(res_pu_drv), 255);
    chk("R10 reset term result", int'(res_pu_term), 255);
    chk("R10 reset fail flags", int'({fail_pu_drv, fail_pd_drv, fail_pd_term}), 0);
    chk("R11 reset idle", int'({busy, done, cal_en}), 0);

    for (int i = 0; i < 8; i++) begin
      kick(VEC[i][24], int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
      finish_and_check($sformatf("vec%0d", i));
    end

    // R8 power-up sequencing, R10 clear at start, R2/R3 first leg setup
    begin
      int n = 0;
      kick(1'b1, 6, 4, 2);
      chk("R8 imp_en and vref_en on", int'({imp_en, vref_en}), 3);
      chk("R8 cal_en still low", int'(cal_en), 0);
      chk("R10 results cleared at start", int'(res_pd_drv), 255);
      while (!cal_en && n < 100) begin @(negedge clk); n++; end
      chk("R8 settle before cal_en", n, SETTLE);
      chk("R2 first leg vref", int'(vref_sel), 'h3A);
      chk("R3 first leg enables", int'({en_pu, en_pd}), 2);
      chk("R4 sweep starts at 0", int'(pu_code), 0);
      finish_and_check("powerup");
    end

    // R11 start while busy is ignored (other selector would break all legs)
    kick(1'b0, 4, 6, 8);
    repeat (20) @(negedge clk);
    odt_on = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0; odt_on = 1'b0;
    chk("R11 still busy after ignored start", int'(busy), 1);
    chk("R11 sweep not restarted", int'(cal_en), 1);
    finish_and_check("busy_start");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule